// File: doc/BRIEF.md
# Vectorised Compare-Immediate Sequencer

This block runs a single compare-with-immediate operation over a vector of length VL. On a start request it latches two base numbers, one for the integer source register and one for the destination condition field. It also latches a signed immediate, the vector length, and one "is a vector" flag per operand. It then walks the elements in order. For each element it reads one integer register, compares that value with the sign-extended immediate, and writes a 3-bit condition field.

The source register number and the destination field number each move forward by one per element only when their own operand is flagged as a vector. Otherwise that number stays at its base. This lets the scalar-scalar, scalar-vector, vector-scalar and vector-vector forms share one loop.

The register file sits outside the block and is reached through a synchronous read port: data returns one cycle after the read request. Results leave through a one-per-cycle field write port. Reads and writes are pipelined, so in steady state the read of one element and the write of the previous element fall in the same cycle.

Top module: `vcmpi_seq`

## Requirements
- R1: After an accepted start with VL = n > 0, the block issues exactly n register reads and exactly n field writes, for elements 0 to n-1 in order.
- R2: For element k the read address is (source base + k) mod 2^REG_AW when the source is flagged as a vector, and the source base otherwise.
- R3: For element k the written field index is (destination base + k) mod 2^CRF_AW when the destination is flagged as a vector, and the destination base otherwise, so with a scalar destination the last element's result is the one that remains.
- R4: The written field holds bit 2 = less-than, bit 1 = greater-than and bit 0 = equal. It comes from a signed compare of the read value with the immediate sign-extended to the data width, and exactly one bit is set.
- R5: With the start sampled at clock edge 0, the read for element k is requested in cycle k+1, its data is expected in cycle k+2, and its field write is presented in cycle k+2.
- R6: With VL = 0 the block requests no read and presents no write, and done_o is high in cycle 1.
- R7: done_o is a single-cycle pulse. For VL = n > 0 it is high in cycle n+2, the cycle after the last write.
- R8: ready_o is low from the accepted start until the last write has left. A start raised while ready_o is low is ignored, with no effect on the running sequence's reads, writes, results or done timing.
- R9: After reset ready_o is high, and rd_en_o, wr_en_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted when ready_o is high |
| ready_o | output | 1 | Idle and able to accept a start |
| src_base_i | input | REG_AW | Base integer register number |
| dst_base_i | input | CRF_AW | Base condition field number |
| imm_i | input | IMM_W | Signed immediate |
| vl_i | input | VL_W | Vector length |
| src_vec_i | input | 1 | Source operand is a vector |
| dst_vec_i | input | 1 | Destination operand is a vector |
| rd_en_o | output | 1 | Register read request |
| rd_addr_o | output | REG_AW | Register read address |
| rd_data_i | input | DATA_W | Read data, valid the cycle after rd_en_o |
| wr_en_o | output | 1 | Condition field write strobe |
| wr_addr_o | output | CRF_AW | Condition field index |
| wr_field_o | output | 3 | Condition field value {lt, gt, eq} |
| done_o | output | 1 | Sequence complete pulse |

## Verification
The read of element k+1 and the field write of element k land in the same cycle whenever VL is at least 2. That overlap is the point where a mis-staged destination index or a compare against the wrong returned data would show. The bench sweeps VL from 0 to 9 under all four vector-flag combinations and several immediates. It logs the cycle and address of every read and every write and requires back-to-back reads and writes at the exact cycles given by R5. It also rebuilds the final condition field contents from the requirements and compares them, which exposes any read/write pairing error. A spurious start held high during a run checks that the overlap is not disturbed.

// File: rtl/vcmpi_pkg.sv
package vcmpi_pkg;

    localparam int CMP_W = 64;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } crf_t;

    function automatic crf_t cmp3(input logic signed [CMP_W-1:0] a,
                                  input logic signed [CMP_W-1:0] b);
        crf_t r;
        r.lt = (a < b);
        r.gt = (a > b);
        r.eq = (a == b);
        return r;
    endfunction

endpackage

// File: rtl/vcmpi_idx_gen.sv
module vcmpi_idx_gen #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic          vec_i,
    input  logic          step_i,
    output logic [AW-1:0] idx_o,
    output logic          vec_o
);
    logic [AW-1:0] idx_q;
    logic          vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            vec_q <= 1'b0;
        end else if (load_i) begin
            idx_q <= base_i;
            vec_q <= vec_i;
        end else if (step_i && vec_q) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_o = idx_q;
    assign vec_o = vec_q;
endmodule

// File: rtl/vcmpi_cmp_stage.sv
module vcmpi_cmp_stage import vcmpi_pkg::*; #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8,
    parameter int CRF_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  logic              last_i,
    input  logic [CRF_AW-1:0] dst_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [CRF_AW-1:0] wr_addr_o,
    output logic [2:0]        wr_field_o,
    output logic              fin_o
);
    logic              s_v_q;
    logic              s_last_q;
    logic [CRF_AW-1:0] s_dst_q;
    logic signed [CMP_W-1:0] a_ext;
    logic signed [CMP_W-1:0] b_ext;
    crf_t              field;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_v_q    <= 1'b0;
            s_last_q <= 1'b0;
            s_dst_q  <= '0;
        end else begin
            s_v_q    <= issue_i;
            s_last_q <= issue_i && last_i;
            if (issue_i) s_dst_q <= dst_i;
        end
    end

    always_comb begin
        a_ext = {{(CMP_W-DATA_W){rd_data_i[DATA_W-1]}}, rd_data_i};
        b_ext = {{(CMP_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        field = cmp3(a_ext, b_ext);
    end

    assign wr_en_o    = s_v_q;
    assign wr_addr_o  = s_dst_q;
    assign wr_field_o = field;
    assign fin_o      = s_v_q && s_last_q;
endmodule

// File: rtl/vcmpi_seq.sv
module vcmpi_seq import vcmpi_pkg::*; #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8,
    parameter int REG_AW = 5,
    parameter int CRF_AW = 3,
    parameter int VL_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              ready_o,
    input  logic [REG_AW-1:0] src_base_i,
    input  logic [CRF_AW-1:0] dst_base_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic              src_vec_i,
    input  logic              dst_vec_i,
    output logic              rd_en_o,
    output logic [REG_AW-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [CRF_AW-1:0] wr_addr_o,
    output logic [2:0]        wr_field_o,
    output logic              done_o
);
    localparam logic [VL_W-1:0] VL_ONE = VL_W'(1);

    seq_state_e        state_q;
    logic [VL_W-1:0]   vl_q;
    logic [VL_W-1:0]   cnt_q;
    logic [IMM_W-1:0]  imm_q;
    logic              done_q;
    logic              accept;
    logic              issue;
    logic              last;
    logic              fin;
    logic              src_vec_q;
    logic              dst_vec_q;
    logic [REG_AW-1:0] src_idx;
    logic [CRF_AW-1:0] dst_idx;

    assign ready_o = (state_q == ST_IDLE) && !wr_en_o;
    assign accept  = start_i && ready_o;
    assign issue   = (state_q == ST_RUN);
    assign last    = (cnt_q == (vl_q - VL_ONE));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vl_q    <= '0;
            cnt_q   <= '0;
            imm_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= fin || (accept && (vl_i == '0));
            if (accept) begin
                vl_q  <= vl_i;
                imm_q <= imm_i;
                cnt_q <= '0;
                if (vl_i != '0) state_q <= ST_RUN;
            end else if (issue) begin
                cnt_q <= cnt_q + VL_ONE;
                if (last) state_q <= ST_IDLE;
            end
        end
    end

    vcmpi_idx_gen #(.AW(REG_AW)) src_gen_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .base_i (src_base_i),
        .vec_i  (src_vec_i),
        .step_i (issue),
        .idx_o  (src_idx),
        .vec_o  (src_vec_q)
    );

    vcmpi_idx_gen #(.AW(CRF_AW)) dst_gen_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .base_i (dst_base_i),
        .vec_i  (dst_vec_i),
        .step_i (issue),
        .idx_o  (dst_idx),
        .vec_o  (dst_vec_q)
    );

    vcmpi_cmp_stage #(.DATA_W(DATA_W), .IMM_W(IMM_W), .CRF_AW(CRF_AW)) cmp_i (
        .clk        (clk),
        .rst        (rst),
        .issue_i    (issue),
        .last_i     (last),
        .dst_i      (dst_idx),
        .imm_i      (imm_q),
        .rd_data_i  (rd_data_i),
        .wr_en_o    (wr_en_o),
        .wr_addr_o  (wr_addr_o),
        .wr_field_o (wr_field_o),
        .fin_o      (fin)
    );

    assign rd_en_o   = issue;
    assign rd_addr_o = src_idx;
    assign done_o    = done_q;
endmodule

// File: rtl/vcmpi_seq_chk.sv
module vcmpi_seq_chk #(
    parameter int REG_AW = 5,
    parameter int CRF_AW = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ready_o,
    input logic              rd_en_o,
    input logic [REG_AW-1:0] rd_addr_o,
    input logic              wr_en_o,
    input logic [CRF_AW-1:0] wr_addr_o,
    input logic [2:0]        wr_field_o,
    input logic              done_o,
    input logic              src_vec_q,
    input logic              dst_vec_q
);
    AST_FIELD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> ($countones(wr_field_o) == 1)); // R4

    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> $past(rd_en_o)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> !rd_en_o); // R8

    AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
        (rd_en_o && $past(rd_en_o)) |->
            (rd_addr_o == REG_AW'($past(rd_addr_o) + (src_vec_q ? 1 : 0)))); // R2

    AST_DST_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && $past(wr_en_o)) |->
            (wr_addr_o == CRF_AW'($past(wr_addr_o) + (dst_vec_q ? 1 : 0)))); // R3
endmodule

bind vcmpi_seq vcmpi_seq_chk #(.REG_AW(REG_AW), .CRF_AW(CRF_AW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ready_o    (ready_o),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_field_o (wr_field_o),
    .done_o     (done_o),
    .src_vec_q  (src_vec_q),
    .dst_vec_q  (dst_vec_q)
);

// File: tb/vcmpi_seq_tb.sv
`timescale 1ns/1ps
module vcmpi_seq_tb_top;
    localparam int DATA_W = 16;
    localparam int IMM_W  = 8;
    localparam int REG_AW = 5;
    localparam int CRF_AW = 3;
    localparam int VL_W   = 4;
    localparam int NREG   = 1 << REG_AW;
    localparam int NCRF   = 1 << CRF_AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              ready_o;
    logic [REG_AW-1:0] src_base_i = '0;
    logic [CRF_AW-1:0] dst_base_i = '0;
    logic [IMM_W-1:0]  imm_i = '0;
    logic [VL_W-1:0]   vl_i = '0;
    logic              src_vec_i = 1'b0;
    logic              dst_vec_i = 1'b0;
    logic              rd_en_o;
    logic [REG_AW-1:0] rd_addr_o;
    logic [DATA_W-1:0] rd_data_i = '0;
    logic              wr_en_o;
    logic [CRF_AW-1:0] wr_addr_o;
    logic [2:0]        wr_field_o;
    logic              done_o;

    always #2.5 clk = ~clk;

    vcmpi_seq #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REG_AW(REG_AW),
                .CRF_AW(CRF_AW), .VL_W(VL_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .ready_o(ready_o),
        .src_base_i(src_base_i), .dst_base_i(dst_base_i), .imm_i(imm_i),
        .vl_i(vl_i), .src_vec_i(src_vec_i), .dst_vec_i(dst_vec_i),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_field_o(wr_field_o),
        .done_o(done_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nrd, nwr, ndone, done_cyc;
    int rd_addr_log [0:31];
    int rd_cyc_log  [0:31];
    int wr_cyc_log  [0:31];
    logic [2:0] cr_seen [0:NCRF-1];

    function automatic int regval(input int a);
        if (a % 2 == 0) return (a - 16) * 9;
        return a - 16;
    endfunction

    function automatic logic [2:0] expfield(input int v, input int imm);
        if (v < imm) return 3'b100;
        if (v > imm) return 3'b010;
        return 3'b001;
    endfunction

    // synchronous register file model: data one cycle after the request
    always @(posedge clk) begin
        if (rd_en_o) rd_data_i <= DATA_W'(regval(int'(rd_addr_o)));
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (rd_en_o) begin
            if (nrd < 32) begin
                rd_addr_log[nrd] = int'(rd_addr_o);
                rd_cyc_log[nrd]  = cyc;
            end
            nrd++;
        end
        if (wr_en_o) begin
            cr_seen[wr_addr_o] = wr_field_o;
            if (nwr < 32) wr_cyc_log[nwr] = cyc;
            nwr++;
        end
        if (done_o) begin
            done_cyc = cyc;
            ndone++;
        end
    endtask

    task automatic run(input int ra, input int ba, input int imm, input int vl,
                       input bit sv, input bit dv, input bit spurious);
        int t0;
        int lat;
        logic [2:0] exp_cr [0:NCRF-1];
        nrd = 0; nwr = 0; ndone = 0; done_cyc = -1;
        for (int f = 0; f < NCRF; f++) begin
            cr_seen[f] = 3'b000;
            exp_cr[f]  = 3'b000;
        end
        src_base_i = REG_AW'(ra);
        dst_base_i = CRF_AW'(ba);
        imm_i      = IMM_W'(imm);
        vl_i       = VL_W'(vl);
        src_vec_i  = sv;
        dst_vec_i  = dv;
        start_i    = 1'b1;
        t0 = cyc;
        tick();
        start_i = 1'b0;
        if (spurious) begin
            check(ready_o == 1'b0, "R8 busy", int'(ready_o), 0);
            src_base_i = REG_AW'(ra + 5);
            dst_base_i = CRF_AW'(ba + 3);
            imm_i      = IMM_W'(-imm);
            vl_i       = VL_W'(1);
            src_vec_i  = !sv;
            dst_vec_i  = !dv;
            start_i    = 1'b1;
            tick();
            tick();
            start_i = 1'b0;
        end
        for (int w = 0; w < 40 && ndone == 0; w++) tick();
        tick();
        tick();
        lat = (vl == 0) ? 1 : vl + 2;
        check(ndone == 1, "R7 done count", ndone, 1);
        check(done_cyc == t0 + lat, (vl == 0) ? "R6 done cycle" : "R7 done cycle",
              done_cyc - t0, lat);
        check(nrd == vl, (vl == 0) ? "R6 reads" : "R1 reads", nrd, vl);
        check(nwr == vl, (vl == 0) ? "R6 writes" : "R1 writes", nwr, vl);
        for (int k = 0; k < vl && k < nrd && k < nwr; k++) begin
            int ea;
            ea = (ra + (sv ? k : 0)) % NREG;
            check(rd_addr_log[k] == ea, "R2 read addr", rd_addr_log[k], ea);
            check(rd_cyc_log[k] == t0 + 1 + k, "R5 read cycle", rd_cyc_log[k] - t0, 1 + k);
            check(wr_cyc_log[k] == t0 + 2 + k, "R5 write cycle", wr_cyc_log[k] - t0, 2 + k);
            exp_cr[(ba + (dv ? k : 0)) % NCRF] = expfield(regval(ea), imm);
        end
        for (int f = 0; f < NCRF; f++)
            check(cr_seen[f] == exp_cr[f], spurious ? "R8 field" : "R3/R4 field",
                  int'(cr_seen[f]), int'(exp_cr[f]));
    endtask

    initial begin
        int imms [0:4];
        imms = '{-128, -1, 0, 5, 127};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        check(ready_o == 1'b1, "R9 ready", int'(ready_o), 1);
        check(rd_en_o == 1'b0, "R9 rd_en", int'(rd_en_o), 0);
        check(wr_en_o == 1'b0, "R9 wr_en", int'(wr_en_o), 0);
        check(done_o == 1'b0, "R9 done", int'(done_o), 0);
        for (int vl = 0; vl < 10; vl++)
            for (int m = 0; m < 4; m++)
                for (int j = 0; j < 5; j++)
                    run((vl * 7 + j * 3 + 20) % NREG, (vl * 3 + m) % NCRF, imms[j],
                        vl, m[0], m[1], 1'b0);
        // spurious starts during busy runs
        run(29, 6, 5, 6, 1'b1, 1'b1, 1'b1);
        run(14, 2, -1, 4, 1'b1, 1'b0, 1'b1);
        run(3, 7, 0, 9, 1'b0, 1'b1, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule